// File: doc/BRIEF.md
# Saturating Rounding Doubling Multiply-Accumulate Unit

This block is a packed-vector arithmetic unit. Each cycle it can accept three 32-bit operand words: two multiplicands and an accumulator. For each signed element it forms the doubled product of the multiplicands and keeps the high half. It adds that high half to the accumulator element, or subtracts it when the subtract select is high. The result is rounded once and clamped to the signed element range. The accumulator is merged into the product sum before the single rounding step, so no intermediate rounding error builds up.

A mode input chooses how the word is split. It is either two independent 16-bit lanes or one 32-bit element. Results come out registered, one clock after the request. A sticky saturation flag records that some lane has clipped since the flag was last cleared. Only the clear input can reset it.

Top module: `sqrdm_unit`

## Requirements
- R1: With `elem_mode`=0, each 16-bit lane result equals ((acc·2^15) + a·b + 2^14) arithmetic-shifted right by 15, when that value fits in 16 signed bits.
- R2: With `elem_mode`=1, the 32-bit result equals ((acc·2^31) + a·b + 2^30) arithmetic-shifted right by 31, when that value fits in 32 signed bits.
- R3: In 16-bit mode, a lane whose shifted value is out of range returns 16'h7FFF if the value is positive and 16'h8000 if it is negative.
- R4: In 32-bit mode, an out-of-range value returns 32'h7FFFFFFF if positive and 32'h80000000 if negative.
- R5: In 16-bit mode, lane 0 takes bits [15:0] of all three operands and lane 1 takes bits [31:16]. Each lane writes back to the same bit positions, and neither lane affects the other.
- R6: With `sub`=1, the product term is negated before the rounding constant is added. The shift and saturation steps are unchanged.
- R7: An accepted request in which any lane saturates makes `sat_flag` read 1 after that clock edge. A set flag stays set while `clr_sat` is low.
- R8: `clr_sat` high at a clock edge makes `sat_flag` 0 after that edge, unless an accepted request saturates in the same cycle. In that case the flag reads 1.
- R9: `out_valid` equals `in_valid` delayed by one clock. `out_data` changes only on edges where `in_valid` was high, and otherwise holds its last value.
- R10: While `rst_n` is low, `out_valid`, `out_data` and `sat_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid this cycle |
| elem_mode | input | 1 | 0: two 16-bit lanes, 1: one 32-bit element |
| sub | input | 1 | 0: accumulate, 1: subtract the product term |
| op_a | input | 32 | Packed first multiplicand |
| op_b | input | 32 | Packed second multiplicand |
| op_acc | input | 32 | Packed accumulator |
| clr_sat | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result valid |
| out_data | output | 32 | Packed saturated result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The sticky-flag clear and a new saturation event can land on the same clock edge, and the set must win. The bench provokes this by raising `clr_sat` in the same cycle as a request that squares the most negative 16-bit value. It then checks that the flag reads 1. A clear with no accompanying request must read 0. The reference model tracks the flag as (old and not clear) or (valid and any lane clipped), and the design's flag is compared against it after every edge.

// File: rtl/sqrdm_pkg.sv
`timescale 1ns/1ps
package sqrdm_pkg;
    localparam int WORD_W   = 32;
    localparam int NARROW_W = 16;

    typedef enum logic {
        MODE_DUAL16   = 1'b0,
        MODE_SINGLE32 = 1'b1
    } elem_mode_e;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } out_reg_t;
endpackage

// File: rtl/sqrdm_lane.sv
`timescale 1ns/1ps
// One signed lane: (acc << (W-1)) +/- a*b + 2^(W-2), shift, clamp.
module sqrdm_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] acc_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);
    localparam int SW = 2*W + 2;
    localparam logic signed [SW-1:0] RND    = SW'(1) <<< (W-2);
    localparam logic [W-1:0]         POSMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0]         NEGMIN = {1'b1, {(W-1){1'b0}}};

    logic signed [2*W-1:0] prod;
    logic signed [SW-1:0]  prod_x;
    logic signed [SW-1:0]  acc_x;
    logic signed [SW-1:0]  sum;
    logic signed [SW-1:0]  sum_sh;
    logic [W+2:0]          hi;
    logic                  fits;

    always_comb begin
        prod   = $signed(a_i) * $signed(b_i);
        prod_x = {{2{prod[2*W-1]}}, prod};
        acc_x  = {{3{acc_i[W-1]}}, acc_i, {(W-1){1'b0}}};
        sum    = acc_x + (sub_i ? -prod_x : prod_x) + RND;
        sum_sh = sum >>> (W-1);
        hi     = sum_sh[SW-1:W-1];
        fits   = (&hi) | ~(|hi);
        sat_o  = ~fits;
        if (fits) begin
            res_o = sum_sh[W-1:0];
        end else begin
            res_o = sum_sh[SW-1] ? NEGMIN : POSMAX;
        end
    end
endmodule

// File: rtl/sqrdm_lanes.sv
`timescale 1ns/1ps
// Splits the word into narrow lanes or one wide element and selects by mode.
module sqrdm_lanes #(
    parameter int WORD = 32,
    parameter int NARROW = 16
) (
    input  logic              elem_mode_i,
    input  logic              sub_i,
    input  logic [WORD-1:0]   a_i,
    input  logic [WORD-1:0]   b_i,
    input  logic [WORD-1:0]   acc_i,
    output logic [WORD-1:0]   res_o,
    output logic [WORD/NARROW-1:0] nsat_o,
    output logic              wsat_o,
    output logic              sat_any_o
);
    localparam int NL = WORD / NARROW;

    logic [WORD-1:0] nres;
    logic [NL-1:0]   nsat;
    logic [WORD-1:0] wres;
    logic            wsat;

    for (genvar i = 0; i < NL; i++) begin : g_narrow
        sqrdm_lane #(.W(NARROW)) u_lane (
            .a_i   (a_i[i*NARROW +: NARROW]),
            .b_i   (b_i[i*NARROW +: NARROW]),
            .acc_i (acc_i[i*NARROW +: NARROW]),
            .sub_i (sub_i),
            .res_o (nres[i*NARROW +: NARROW]),
            .sat_o (nsat[i])
        );
    end

    sqrdm_lane #(.W(WORD)) u_wide (
        .a_i   (a_i),
        .b_i   (b_i),
        .acc_i (acc_i),
        .sub_i (sub_i),
        .res_o (wres),
        .sat_o (wsat)
    );

    always_comb begin
        if (elem_mode_i == sqrdm_pkg::MODE_SINGLE32) begin
            res_o     = wres;
            sat_any_o = wsat;
        end else begin
            res_o     = nres;
            sat_any_o = |nsat;
        end
        nsat_o = nsat;
        wsat_o = wsat;
    end
endmodule

// File: rtl/sqrdm_sticky.sv
`timescale 1ns/1ps
// Sticky saturation flag: set wins over clear.
module sqrdm_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/sqrdm_unit.sv
`timescale 1ns/1ps
module sqrdm_unit
    import sqrdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              elem_mode,
    input  logic              sub,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] op_acc,
    input  logic              clr_sat,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              sat_flag
);
    localparam int NL = WORD_W / NARROW_W;

    logic [WORD_W-1:0] lane_res;
    logic [NL-1:0]     nsat;
    logic              wsat;
    logic              sat_any;
    out_reg_t          st_d, st_q;

    sqrdm_lanes #(.WORD(WORD_W), .NARROW(NARROW_W)) u_lanes (
        .elem_mode_i (elem_mode),
        .sub_i       (sub),
        .a_i         (op_a),
        .b_i         (op_b),
        .acc_i       (op_acc),
        .res_o       (lane_res),
        .nsat_o      (nsat),
        .wsat_o      (wsat),
        .sat_any_o   (sat_any)
    );

    sqrdm_sticky u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (in_valid & sat_any),
        .clr_i  (clr_sat),
        .flag_o (sat_flag)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.data = lane_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;

    // R9: valid pipeline and data hold
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));
    // R3: clipped narrow lane lands on a limit
    p_lane0_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && elem_mode == MODE_DUAL16 && nsat[0]) |=>
        (out_data[15:0] == 16'h7FFF || out_data[15:0] == 16'h8000));
    // R4: clipped wide element lands on a limit
    p_wide_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && elem_mode == MODE_SINGLE32 && wsat) |=>
        (out_data == 32'h7FFFFFFF || out_data == 32'h80000000));
    // R7: saturation sets the flag, and it holds without clear
    p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_any) |=> sat_flag);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !clr_sat) |=> sat_flag);
    // R8: clear without new saturation empties the flag
    p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sat && !(in_valid && sat_any)) |=> !sat_flag);
endmodule

// File: tb/sqrdm_unit_tb.sv
`timescale 1ns/1ps
module sqrdm_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        elem_mode = 1'b0;
    logic        sub = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_acc = '0;
    logic        clr_sat = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        sat_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] data;
        string       req;
    } exp_t;
    exp_t        q[$];
    logic        exp_valid = 1'b0;
    logic        exp_flag = 1'b0;
    string       flag_req = "R7";
    logic [31:0] last_data = '0;
    bit          mon_on = 0;

    always #2.5 clk = ~clk;

    sqrdm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .elem_mode(elem_mode),
        .sub(sub), .op_a(op_a), .op_b(op_b), .op_acc(op_acc), .clr_sat(clr_sat),
        .out_valid(out_valid), .out_data(out_data), .sat_flag(sat_flag)
    );

    function automatic void ref_lane(input int w, input logic signed [127:0] a,
            input logic signed [127:0] b, input logic signed [127:0] acc,
            input logic s, output logic [31:0] r, output logic sat);
        logic signed [127:0] p, t, mx, mn;
        p  = a * b;
        t  = (acc <<< (w-1)) + (s ? -p : p) + (128'sd1 <<< (w-2));
        t  = t >>> (w-1);
        mx = (128'sd1 <<< (w-1)) - 1;
        mn = -(128'sd1 <<< (w-1));
        sat = 1'b0;
        if (t > mx) begin t = mx; sat = 1'b1; end
        else if (t < mn) begin t = mn; sat = 1'b1; end
        r = t[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic go(input logic v, input logic m, input logic s,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] acc, input logic c, input string req);
        logic signed [127:0] sa, sb, sc;
        logic [31:0] r0, r1, rw;
        logic s0, s1, sw, any;
        exp_t it;
        @(negedge clk);
        in_valid = v; elem_mode = m; sub = s;
        op_a = a; op_b = b; op_acc = acc; clr_sat = c;
        sa = $signed(a[15:0]); sb = $signed(b[15:0]); sc = $signed(acc[15:0]);
        ref_lane(16, sa, sb, sc, s, r0, s0);
        sa = $signed(a[31:16]); sb = $signed(b[31:16]); sc = $signed(acc[31:16]);
        ref_lane(16, sa, sb, sc, s, r1, s1);
        sa = $signed(a); sb = $signed(b); sc = $signed(acc);
        ref_lane(32, sa, sb, sc, s, rw, sw);
        any = m ? sw : (s0 | s1);
        if (v) begin
            it.data = m ? rw : {r1[15:0], r0[15:0]};
            it.req  = req;
            q.push_back(it);
        end
        exp_valid = v;
        if (c) flag_req = "R8";
        else   flag_req = "R7";
        exp_flag = (exp_flag & ~c) | (v & any);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) go(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b0, "R9");
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                exp_t it;
                check("R9 valid", {31'b0, out_valid}, {31'b0, exp_valid});
                if (out_valid) begin
                    if (q.size() == 0) begin
                        checks++; errors++;
                        $display("FAIL R9: actual unexpected result %h expected none", out_data);
                    end else begin
                        it = q.pop_front();
                        check(it.req, out_data, it.data);
                        last_data = it.data;
                    end
                end else begin
                    check("R9 hold", out_data, last_data);
                end
                check(flag_req, {31'b0, sat_flag}, {31'b0, exp_flag});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        in_valid = 1'b1; op_a = 32'h7FFF7FFF; op_b = 32'h7FFF7FFF;
        repeat (3) @(posedge clk);
        #1;
        check("R10 valid", {31'b0, out_valid}, 32'd0);
        check("R10 data", out_data, 32'd0);
        check("R10 flag", {31'b0, sat_flag}, 32'd0);
        @(negedge clk);
        in_valid = 1'b0; op_a = '0; op_b = '0;
        rst_n = 1'b1;
        mon_on = 1;

        // R1: plain 16-bit lanes, zero accumulator and small values
        go(1, 0, 0, 32'h4000_2000, 32'h4000_4000, 32'h0000_0000, 0, "R1");
        go(1, 0, 0, 32'h0003_FFFD, 32'h1234_0100, 32'h0100_FF00, 0, "R1");
        // R5: lane 0 clips, lane 1 ordinary
        go(1, 0, 0, 32'h0010_8000, 32'h0020_8000, 32'h0005_0000, 0, "R5");
        idle(1);
        // R7: flag stays set across ordinary requests
        go(1, 0, 0, 32'h0001_0001, 32'h0001_0001, 32'h0000_0000, 0, "R7");
        idle(2);
        // R8: clear alone empties flag
        go(0, 0, 0, '0, '0, '0, 1, "R8");
        idle(1);
        // R3: most negative squared -> 7FFF both lanes; with clear in same cycle (R8)
        go(1, 0, 0, 32'h8000_8000, 32'h8000_8000, 32'h0000_0000, 1, "R3");
        go(0, 0, 0, '0, '0, '0, 1, "R8");
        // R3: max accumulator plus positive product
        go(1, 0, 0, 32'h4000_4000, 32'h4000_4000, 32'h7FFF_7FFF, 0, "R3");
        // R3/R6: negative clip via subtract
        go(1, 0, 1, 32'h4000_4000, 32'h4000_4000, 32'h8000_8000, 1, "R6");
        // R6: subtract ordinary
        go(1, 0, 1, 32'h1000_0200, 32'h0300_0400, 32'h0100_0000, 0, "R6");
        idle(1);
        go(0, 0, 0, '0, '0, '0, 1, "R8");
        // R2: 32-bit element
        go(1, 1, 0, 32'h4000_0000, 32'h2000_0000, 32'h0000_0000, 0, "R2");
        go(1, 1, 0, 32'h0001_2345, 32'hFFFE_0011, 32'h1000_0000, 0, "R2");
        // R4: 32-bit clips
        go(1, 1, 0, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 0, "R4");
        go(1, 1, 0, 32'h4000_0000, 32'h4000_0000, 32'h7FFF_FFFF, 0, "R4");
        go(1, 1, 1, 32'h4000_0000, 32'h4000_0000, 32'h8000_0000, 0, "R4");
        go(1, 1, 1, 32'h0000_1000, 32'h0002_0000, 32'h0000_0300, 0, "R6");
        idle(2);
        // Random vectors both modes, both directions
        for (int k = 0; k < 200; k++) begin
            logic m, s, c;
            m = k[0]; s = k[1];
            c = ($urandom % 8) == 0;
            go(($urandom % 4) != 0, m, s, $urandom, $urandom, $urandom, c,
               m ? "R2" : "R1");
        end
        idle(3);
        check("R9 drain", q.size(), 32'd0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule